// File: doc/BRIEF.md
# Clock Output Power-Management Controller

This block is the control logic of a multi-output clock buffer. It decides, for each of several differential clock output pairs and for one single-ended reference output, whether the output runs, is parked at a static level, is powered down, or floats. The decision rests on a power-good input (high means power is good, low requests power-down), on the lock status of the PLL, on an active-low enable pin per pair, and on an enable register bit per pair. The PLL, the analog drivers, the spread-spectrum logic and the serial management engine sit outside the block. Configuration bits come in as plain register inputs.

The pins from the board (power-good, lock, enable pins and the address select) pass through multi-flop synchronizers. The first time power-good is seen high, the block samples the address select pin once and presents the serial-management address. It also releases the reference output from high impedance, and it holds that state until the next reset. Every state change is applied only in a cycle where the output clock is reported to be in its low phase, so an output never sees a shortened pulse. The PLL clock is held off until lock, so start-up is clean.

Top module: `clkout_pm_ctrl`

## Requirements
- R1: After reset every pair code is 10, every pair park level is 00, the reference code is 11, `addr_valid` is 0 and `smb_addr` is 0.
- R2: State codes are 00 running, 01 disabled, 10 powered down and 11 high-impedance. A pair code is never 11.
- R3: While power-good is low, every pair has code 10 and a park level equal to `pd_level`, whatever the enable inputs and lock are. In each 2-bit park field, bit 1 is the true leg and bit 0 is the complement leg.
- R4: While power-good is high and the PLL is not locked, every pair has code 01 with park level 01 (true low, complement high).
- R5: While power-good is high and the PLL is locked, pair i has code 00 (park 00) exactly when `oe_reg[i]` is 1 and `oe_n_pin[i]` is 0. Otherwise it has code 01 with park 01. A pair never runs before power-good has first been seen.
- R6: The reference code stays 11 until power-good is first seen high. From then on it is 00 while power-good is high.
- R7: After the first power-good, while power-good is low, the reference code is 01 if `ref_keep` is 0 and 00 if `ref_keep` is 1.
- R8: On the first power-good, `addr_valid` goes to 1 and `smb_addr` becomes 0x68 (1101000) if the select pin is 0, or 0x6A (1101010) if it is 1. Later power-good edges and select changes leave it unchanged until reset.
- R9: A change on a synchronized pin (power-good, lock, enable pins, select) shows at the outputs after the (SYNC_STAGES+1)-th rising edge and not before. A change on `oe_reg`, `pd_level` or `ref_keep` shows after the next rising edge.
- R10: While `out_low` is 0, pair codes, park levels and the reference code hold. A pending change is applied at the first rising edge that samples `out_low` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd | input | 1 | Power-good; low requests power-down |
| pll_lock | input | 1 | PLL lock status |
| adr_sel | input | 1 | Serial address select pin |
| oe_n_pin | input | NUM_PAIRS | Active-low output enable pins, one per pair |
| oe_reg | input | NUM_PAIRS | Output enable register bits, one per pair |
| pd_level | input | 2 | Power-down park level {true, complement} |
| ref_keep | input | 1 | Keep reference running while powered down |
| out_low | input | 1 | Output clock is in its low phase |
| pair_state | output | 2*NUM_PAIRS | State code per pair, pair i at bits 2i+1:2i |
| pair_park | output | 2*NUM_PAIRS | Static level per pair {true, complement} |
| ref_state | output | 2 | Reference output state code |
| addr_valid | output | 1 | Power-good has been seen; address latched |
| smb_addr | output | ADDR_W | Latched serial-management address |

## Verification
With the default two synchronizer stages, a change on any synchronized pin is due three rising edges later, and a register input is due one edge later. The scoreboard driver pushes each expected result tagged with that exact cycle. For synchronized stimulus it also pushes the old result for the cycle before, so an output that moves early is caught as well as one that moves late. For the low-phase gating, the old state is queued for every cycle while `out_low` is held low, and the new state is queued for the first edge after `out_low` returns high. The monitor compares only at falling edges, where the registered outputs are stable.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

   typedef enum logic [1:0] {
      ST_RUN = 2'b00,
      ST_DIS = 2'b01,
      ST_PD  = 2'b10,
      ST_HIZ = 2'b11
   } out_st_e;

   // park levels: bit 1 = true leg, bit 0 = complement leg
   localparam logic [1:0] PARK_DIS = 2'b01;
   localparam logic [1:0] PARK_RUN = 2'b00;
   localparam logic [1:0] PARK_RST = 2'b00;

endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkpm_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("clkpm_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/clkpm_first_pg.sv
module clkpm_first_pg #(
   parameter int                ADDR_W    = 7,
   parameter logic [ADDR_W-1:0] ADDR_SEL0 = 7'b1101000,
   parameter logic [ADDR_W-1:0] ADDR_SEL1 = 7'b1101010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pg_s,
   input  logic              sel_s,
   output logic              seen_next,
   output logic              seen_q,
   output logic [ADDR_W-1:0] addr_q
);

   logic capture;

   assign seen_next = seen_q | pg_s;
   assign capture   = pg_s & ~seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         addr_q <= '0;
      end else begin
         seen_q <= seen_next;
         if (capture) addr_q <= sel_s ? ADDR_SEL1 : ADDR_SEL0;
      end
   end

endmodule

// File: rtl/clkpm_pair.sv
module clkpm_pair
   import clkpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic       pg,
   input  logic       lock,
   input  logic       en_reg,
   input  logic       en_n,
   input  logic [1:0] pd_lvl,
   output out_st_e    st,
   output logic [1:0] park
);

   out_st_e    st_d;
   logic [1:0] park_d;
   logic       run_ok;

   assign run_ok = lock & en_reg & ~en_n;

   always_comb begin
      if (!pg) begin
         st_d   = ST_PD;
         park_d = pd_lvl;
      end else if (run_ok) begin
         st_d   = ST_RUN;
         park_d = PARK_RUN;
      end else begin
         st_d   = ST_DIS;
         park_d = PARK_DIS;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_PD;
         park <= PARK_RST;
      end else if (upd) begin
         st   <= st_d;
         park <= park_d;
      end
   end

endmodule

// File: rtl/clkpm_ref.sv
module clkpm_ref
   import clkpm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    upd,
   input  logic    seen_next,
   input  logic    pg,
   input  logic    keep,
   output out_st_e st
);

   out_st_e st_d;

   always_comb begin
      if (!seen_next)   st_d = ST_HIZ;
      else if (pg)      st_d = ST_RUN;
      else if (keep)    st_d = ST_RUN;
      else              st_d = ST_DIS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   st <= ST_HIZ;
      else if (upd) st <= st_d;
   end

endmodule

// File: rtl/clkout_pm_ctrl.sv
module clkout_pm_ctrl
   import clkpm_pkg::*;
#(
   parameter int                NUM_PAIRS   = 4,
   parameter int                SYNC_STAGES = 2,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] ADDR_SEL0   = 7'b1101000,
   parameter logic [ADDR_W-1:0] ADDR_SEL1   = 7'b1101010,
   parameter bit                GATE_ON_LOW = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pwrgd,
   input  logic                   pll_lock,
   input  logic                   adr_sel,
   input  logic [NUM_PAIRS-1:0]   oe_n_pin,
   input  logic [NUM_PAIRS-1:0]   oe_reg,
   input  logic [1:0]             pd_level,
   input  logic                   ref_keep,
   input  logic                   out_low,
   output logic [2*NUM_PAIRS-1:0] pair_state,
   output logic [2*NUM_PAIRS-1:0] pair_park,
   output logic [1:0]             ref_state,
   output logic                   addr_valid,
   output logic [ADDR_W-1:0]      smb_addr
);

   localparam int SYNC_W  = NUM_PAIRS + 3;
   localparam int IDX_PG  = NUM_PAIRS;
   localparam int IDX_LK  = NUM_PAIRS + 1;
   localparam int IDX_SEL = NUM_PAIRS + 2;

   generate
      if (NUM_PAIRS < 1 || NUM_PAIRS > 32) begin : g_bad_pairs
         $error("clkout_pm_ctrl: NUM_PAIRS out of range 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkout_pm_ctrl: SYNC_STAGES must be at least 2");
      end
      if (ADDR_SEL0 == ADDR_SEL1) begin : g_bad_addr
         $error("clkout_pm_ctrl: the two addresses must differ");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_in;
   logic [SYNC_W-1:0] syn;
   logic              pg_s, lock_s, sel_s;
   logic              seen_next, seen_q;
   logic              upd;
   out_st_e           ref_st;

   assign raw_in = {adr_sel, pll_lock, pwrgd, oe_n_pin};

   clkpm_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn)
   );

   assign pg_s   = syn[IDX_PG];
   assign lock_s = syn[IDX_LK];
   assign sel_s  = syn[IDX_SEL];

   generate
      if (GATE_ON_LOW) begin : g_gate_low
         assign upd = out_low;
      end else begin : g_gate_none
         assign upd = 1'b1;
      end
   endgenerate

   clkpm_first_pg #(
      .ADDR_W    (ADDR_W),
      .ADDR_SEL0 (ADDR_SEL0),
      .ADDR_SEL1 (ADDR_SEL1)
   ) u_first (
      .clk       (clk),
      .rst_n     (rst_n),
      .pg_s      (pg_s),
      .sel_s     (sel_s),
      .seen_next (seen_next),
      .seen_q    (seen_q),
      .addr_q    (smb_addr)
   );

   assign addr_valid = seen_q;

   generate
      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
         out_st_e    st_i;
         logic [1:0] park_i;

         clkpm_pair u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd),
            .pg     (pg_s),
            .lock   (lock_s),
            .en_reg (oe_reg[i]),
            .en_n   (syn[i]),
            .pd_lvl (pd_level),
            .st     (st_i),
            .park   (park_i)
         );

         assign pair_state[2*i +: 2] = st_i;
         assign pair_park[2*i +: 2]  = park_i;
      end
   endgenerate

   clkpm_ref u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (upd),
      .seen_next (seen_next),
      .pg        (pg_s),
      .keep      (ref_keep),
      .st        (ref_st)
   );

   assign ref_state = ref_st;

endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk #(
   parameter int                NUM_PAIRS   = 4,
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] ADDR_SEL0   = 7'b1101000,
   parameter logic [ADDR_W-1:0] ADDR_SEL1   = 7'b1101010,
   parameter bit                GATE_ON_LOW = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   out_low,
   input logic [2*NUM_PAIRS-1:0] pair_state,
   input logic [2*NUM_PAIRS-1:0] pair_park,
   input logic [1:0]             ref_state,
   input logic                   addr_valid,
   input logic [ADDR_W-1:0]      smb_addr
);

   // R6
   ref_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |-> ref_state == 2'b11);

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> addr_valid && $stable(smb_addr));

   // R8
   addr_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> (smb_addr == ADDR_SEL0 || smb_addr == ADDR_SEL1));

   generate
      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pchk
         // R2
         pair_nohiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pair_state[2*i +: 2] != 2'b11);

         // R5
         run_needs_pg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pair_state[2*i +: 2] == 2'b00 |-> addr_valid);

         // R4
         dis_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pair_state[2*i +: 2] == 2'b01 |-> pair_park[2*i +: 2] == 2'b01);
      end

      if (GATE_ON_LOW) begin : g_hold
         // R10
         low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_low |=> $stable(pair_state) && $stable(pair_park) && $stable(ref_state));
      end
   endgenerate

endmodule

bind clkout_pm_ctrl clkpm_chk #(
   .NUM_PAIRS   (NUM_PAIRS),
   .ADDR_W      (ADDR_W),
   .ADDR_SEL0   (ADDR_SEL0),
   .ADDR_SEL1   (ADDR_SEL1),
   .GATE_ON_LOW (GATE_ON_LOW)
) u_clkpm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_low    (out_low),
   .pair_state (pair_state),
   .pair_park  (pair_park),
   .ref_state  (ref_state),
   .addr_valid (addr_valid),
   .smb_addr   (smb_addr)
);

// File: tb/tb_clkout_pm_ctrl.sv
module tb_clkout_pm_ctrl;

   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           pwrgd = 1'b0, pll_lock = 1'b0, adr_sel = 1'b0;
   logic [N-1:0]   oe_n_pin = '0, oe_reg = '1;
   logic [1:0]     pd_level = 2'b00;
   logic           ref_keep = 1'b0, out_low = 1'b1;
   logic [2*N-1:0] pair_state, pair_park;
   logic [1:0]     ref_state;
   logic           addr_valid;
   logic [6:0]     smb_addr;

   clkout_pm_ctrl #(.NUM_PAIRS(N)) dut (
      .clk(clk), .rst_n(rst_n), .pwrgd(pwrgd), .pll_lock(pll_lock),
      .adr_sel(adr_sel), .oe_n_pin(oe_n_pin), .oe_reg(oe_reg),
      .pd_level(pd_level), .ref_keep(ref_keep), .out_low(out_low),
      .pair_state(pair_state), .pair_park(pair_park), .ref_state(ref_state),
      .addr_valid(addr_valid), .smb_addr(smb_addr)
   );

   always #4 clk = ~clk;

   typedef struct {
      int             due;
      logic [2*N-1:0] ps;
      logic [2*N-1:0] pk;
      logic [1:0]     rf;
      logic           av;
      logic [6:0]     ad;
      string          tag;
   } exp_t;

   exp_t sbq[$];
   exp_t last_exp;
   int   cyc = 0;
   int   n_cmp = 0, n_bad = 0;
   bit   done = 0;
   bit   m_seen = 0;
   logic [6:0] m_addr = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic exp_t model(int due, string tag);
      exp_t e;
      e.due = due; e.tag = tag; e.av = m_seen; e.ad = m_addr;
      for (int i = 0; i < N; i++) begin
         if (!pwrgd) begin
            e.ps[2*i +: 2] = 2'b10; e.pk[2*i +: 2] = pd_level;
         end else if (pll_lock && oe_reg[i] && !oe_n_pin[i]) begin
            e.ps[2*i +: 2] = 2'b00; e.pk[2*i +: 2] = 2'b00;
         end else begin
            e.ps[2*i +: 2] = 2'b01; e.pk[2*i +: 2] = 2'b01;
         end
      end
      if (!m_seen)       e.rf = 2'b11;
      else if (pwrgd)    e.rf = 2'b00;
      else if (ref_keep) e.rf = 2'b00;
      else               e.rf = 2'b01;
      return e;
   endfunction

   // monitor: compare queued expectations at their due cycle
   always @(negedge clk) begin
      exp_t e;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         e = sbq.pop_front();
         n_cmp++;
         if (e.due != cyc || pair_state !== e.ps || pair_park !== e.pk ||
             ref_state !== e.rf || addr_valid !== e.av || smb_addr !== e.ad) begin
            n_bad++;
            $display("FAIL %s cyc=%0d: state=%b park=%b ref=%b av=%b addr=%h | exp state=%b park=%b ref=%b av=%b addr=%h (due %0d)",
                     e.tag, cyc, pair_state, pair_park, ref_state, addr_valid, smb_addr,
                     e.ps, e.pk, e.rf, e.av, e.ad, e.due);
         end
      end
   end

   // driver: inputs already changed at this falling edge
   task automatic step(input bit synced, input string tag);
      int   lat;
      exp_t nw;
      lat = synced ? 3 : 1;
      if (lat > 1) begin
         last_exp.due = cyc + lat - 1;
         last_exp.tag = {tag, " R9 not-yet"};
         sbq.push_back(last_exp);
      end
      nw = model(cyc + lat, tag);
      sbq.push_back(nw);
      last_exp = nw;
      repeat (lat + 2) @(negedge clk);
   endtask

   task automatic set_pg(input logic v);
      pwrgd = v;
      if (v && !m_seen) begin
         m_seen = 1;
         m_addr = adr_sel ? 7'h6A : 7'h68;
      end
   endtask

   task automatic do_reset(input string tag);
      rst_n = 1'b0;
      m_seen = 0; m_addr = '0;
      @(negedge clk);
      last_exp = model(cyc + 1, tag);
      sbq.push_back(last_exp);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired, compared=%0d", n_cmp);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset("R1 reset state");

      // R3: power-down level follows register while power-good low
      pd_level = 2'b10;
      step(0, "R3 pd_level=10");

      adr_sel = 1'b1;
      step(1, "R8 select before power-good");

      // R4 R6 R8: first power-good, no lock
      set_pg(1'b1);
      step(1, "R4/R6/R8 first power-good no lock");

      // R5: lock -> all running
      pll_lock = 1'b1;
      step(1, "R5 locked all run");

      oe_n_pin = 4'b0101;
      step(1, "R5 pins 0101");

      oe_reg = 4'b1100;
      step(0, "R5 reg 1100");

      adr_sel = 1'b0;
      step(1, "R8 select change ignored");

      // R7 R3: power-good low again, ref disabled
      set_pg(1'b0);
      step(1, "R7/R3 power-down ref off");

      ref_keep = 1'b1;
      step(0, "R7 ref_keep=1");

      pd_level = 2'b01;
      step(0, "R3 pd_level=01");

      set_pg(1'b1);
      step(1, "R8 second power-good keeps addr");

      // R10: hold while out_low is low
      out_low = 1'b0;
      oe_n_pin = 4'b0000;
      oe_reg = 4'b1111;
      for (int k = 1; k <= 5; k++) begin
         exp_t h;
         h = last_exp;
         h.due = cyc + k;
         h.tag = "R10 held while out_low=0";
         sbq.push_back(h);
      end
      repeat (5) @(negedge clk);
      out_low = 1'b1;
      last_exp = model(cyc + 1, "R10 applied at first out_low edge");
      sbq.push_back(last_exp);
      repeat (3) @(negedge clk);

      pll_lock = 1'b0;
      step(1, "R4 lock lost");

      // second reset, select 0
      set_pg(1'b0);
      pd_level = 2'b00;
      ref_keep = 1'b0;
      step(1, "R7 power-down ref off");
      do_reset("R1 second reset");

      pd_level = 2'b11;
      step(0, "R3 pd_level=11 before first power-good");

      set_pg(1'b1);
      pll_lock = 1'b1;
      step(1, "R8 select 0 gives 0x68");

      repeat (4) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule